// File: doc/BRIEF.md
# Character Display Command Executor

This block is the command engine of a character-matrix display controller. A host sends it requests: command bytes, writes and reads of display or pattern memory, and reads of the busy/address status. The block decodes each command byte by the position of its highest set bit. It keeps the controller state: the address counter, which memory the data accesses go to, the entry mode, the display, cursor and blink enables, the scroll offset and the line, font and bus-width settings. It drives the memory port for data accesses and for the clear sequence, which fills the display memory with blanks.

Each command and each data access keeps the block busy for a fixed number of oscillator ticks, counted from the `osc_tick` input. While it is busy, only status reads are accepted. Every data access moves the address counter one step in the direction set by the entry mode. When the entry mode enables scrolling and the display memory is the target, the access also steps the scroll offset.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host holds the request fields stable. `req_ready` is low whenever the block is busy, except for status reads (`req_rs`=0, `req_rw`=1), which are always ready. Responses come one cycle after acceptance as a single-cycle `rsp_valid` pulse and cannot be stalled.

Top module: `lcd_cmd_exec`

## Requirements
- R1: After reset: address counter 0, display memory targeted, increment mode on, scroll off, display, cursor and blink off, scroll offset 0, 8-bit bus on, one line, short font, not busy, `req_ready` high.
- R2: A command byte (`req_rs`=0, `req_rw`=0) is decoded by its highest set bit. Bits below a command's own fields are ignored: bit 0 of the home command, bits 1..0 of the shift command, bits 1..0 of the function command. Byte 00h is a no-op and does not set busy.
- R3: Byte 01h (clear) writes 20h into every valid display address for the current line mode: 0..79 with one line, 00h..27h and 40h..67h with two lines. No other address is written. It also sets the address counter and the scroll offset to 0 and targets display memory.
- R4: Highest bit 1 (home) sets the address counter and the scroll offset to 0 and targets display memory. It writes no memory.
- R5: Highest bit 2 (entry mode) takes bit 1 as the direction (1 = increment) and bit 0 as the scroll flag. Each data write or read steps the address counter in that direction. When the scroll flag is set and display memory is the target, the access also moves the scroll offset by +1 when incrementing and by -1 when decrementing. It does not move the offset when pattern memory is the target.
- R6: Highest bit 3 loads display-on from bit 2, cursor-on from bit 1 and blink-on from bit 0.
- R7: Highest bit 4 uses bit 3 to choose scroll (1) or cursor move (0), and bit 2 to choose the direction (1 = right). A right scroll moves the offset by -1 and a left scroll by +1. A right cursor move steps the counter up and a left move steps it down. The offset wraps within 0..79 with one line and within 0..39 with two lines.
- R8: Highest bit 5 loads the 8-bit bus flag from bit 4, two-line mode from bit 3 and the tall font from bit 2. It also sets the scroll offset to 0.
- R9: Highest bit 6 loads bits 5..0 into the counter and targets pattern memory. Highest bit 7 loads bits 6..0 into the counter and targets display memory.
- R10: With one line, a display address steps 79→0 upward and 0→79 downward. With two lines, it steps 27h→40h and 67h→00h upward, and 00h→67h and 40h→27h downward. A pattern memory address wraps within 6 bits.
- R11: Clear and home hold busy for 410 ticks. Every other command and every data access holds busy for 10 ticks. Status reads take no busy time.
- R12: While busy, `req_ready` is low for every request except status reads.
- R13: One cycle after a read is accepted, `rsp_valid` is high. For a status read, `rsp_data` is {busy, address counter} as they stood at acceptance. For a data read, `rsp_data` is the memory byte at the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period; times the busy intervals |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_rs | input | 1 | 0: command or status, 1: memory data |
| req_rw | input | 1 | 0: write, 1: read |
| req_data | input | 8 | Command byte or write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 8 | Read response byte |
| ram_sel_cg | output | 1 | Memory select: 1 pattern memory, 0 display memory |
| ram_addr | output | 7 | Memory address |
| ram_we | output | 1 | Memory write enable |
| ram_re | output | 1 | Memory read enable (data due one cycle later) |
| ram_wdata | output | 8 | Memory write data |
| ram_rdata | input | 8 | Memory read data |
| busy | output | 1 | Execution in progress |
| addr_ctr | output | 7 | Address counter |
| target_cg | output | 1 | Data accesses go to pattern memory |
| incr_mode | output | 1 | Entry direction is increment |
| scroll_mode | output | 1 | Data accesses scroll the display |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| shift_ofs | output | 7 | Display scroll offset |
| bus_8bit | output | 1 | 8-bit host bus selected |
| two_line | output | 1 | Two-line mode |
| tall_font | output | 1 | Tall (5x10) font |

## Verification
The assertions take several things about the inputs for granted. The host keeps `req_rs`, `req_rw` and `req_data` stable while a request waits for ready. The memory returns read data exactly one cycle after `ram_re`. `osc_tick` pulses last one cycle and are separated by idle cycles. The stimulus keeps to these rules. Requests are driven on falling edges and held until the cycle after acceptance, and a behavioural memory with one-cycle latency sits beside the block. Ticks come from a free-running counter, one tick in every four clocks, so every busy length falls within a window of a few cycles that the checks allow.

// File: rtl/lcd_exec_pkg.sv
package lcd_exec_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_CLEAR  = 4'd1,
    OP_HOME   = 4'd2,
    OP_ENTRY  = 4'd3,
    OP_DISP   = 4'd4,
    OP_SHIFT  = 4'd5,
    OP_FUNC   = 4'd6,
    OP_CGADDR = 4'd7,
    OP_DDADDR = 4'd8
  } op_e;

endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
  import lcd_exec_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] cmd,
  output op_e               op
);

  // Highest set bit wins: scan upward, later hits override earlier ones.
  always_comb begin
    op = OP_NOP;
    for (int i = 0; i < BYTE_W; i++) begin
      if (cmd[i]) op = op_e'(4'(i + 1));
    end
  end

endmodule

// File: rtl/lcd_addr_step.sv
module lcd_addr_step #(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned CG_W       = 6,
  parameter int unsigned DD_DEPTH   = 80,
  parameter int unsigned LINE2_BASE = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              up,
  input  logic              to_cg,
  input  logic              two_line,
  output logic [ADDR_W-1:0] nxt
);

  localparam int unsigned LINE_LEN = DD_DEPTH / 2;
  localparam logic [ADDR_W-1:0] ONE_LAST = ADDR_W'(DD_DEPTH - 1);
  localparam logic [ADDR_W-1:0] L1_LAST  = ADDR_W'(LINE_LEN - 1);
  localparam logic [ADDR_W-1:0] L2_FIRST = ADDR_W'(LINE2_BASE);
  localparam logic [ADDR_W-1:0] L2_LAST  = ADDR_W'(LINE2_BASE + LINE_LEN - 1);

  logic [CG_W-1:0] cg_nxt;

  assign cg_nxt = up ? addr[CG_W-1:0] + 1'b1 : addr[CG_W-1:0] - 1'b1;

  always_comb begin
    if (to_cg) begin
      nxt = ADDR_W'(cg_nxt);
    end else if (!two_line) begin
      if (up) nxt = (addr == ONE_LAST) ? '0 : addr + 1'b1;
      else    nxt = (addr == '0) ? ONE_LAST : addr - 1'b1;
    end else begin
      if (up) begin
        if (addr == L1_LAST)      nxt = L2_FIRST;
        else if (addr == L2_LAST) nxt = '0;
        else                      nxt = addr + 1'b1;
      end else begin
        if (addr == '0)            nxt = L2_LAST;
        else if (addr == L2_FIRST) nxt = L1_LAST;
        else                       nxt = addr - 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_ofs_step.sv
module lcd_ofs_step #(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned DD_DEPTH = 80
) (
  input  logic [ADDR_W-1:0] ofs,
  input  logic              fwd,
  input  logic              two_line,
  output logic [ADDR_W-1:0] nxt
);

  localparam logic [ADDR_W-1:0] LAST_ONE = ADDR_W'(DD_DEPTH - 1);
  localparam logic [ADDR_W-1:0] LAST_TWO = ADDR_W'(DD_DEPTH / 2 - 1);

  logic [ADDR_W-1:0] last;

  assign last = two_line ? LAST_TWO : LAST_ONE;

  always_comb begin
    if (fwd) nxt = (ofs >= last) ? '0 : ofs + 1'b1;
    else     nxt = (ofs == '0) ? last : ofs - 1'b1;
  end

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int unsigned LONG_TICKS  = 410,
  parameter int unsigned SHORT_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  input  logic tick,
  output logic busy
);

  localparam int unsigned CNT_W = $clog2(LONG_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= long_sel ? CNT_W'(LONG_TICKS) : CNT_W'(SHORT_TICKS);
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  AST_TICK_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && !start) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R11

endmodule

// File: rtl/lcd_cmd_exec.sv
module lcd_cmd_exec
  import lcd_exec_pkg::*;
#(
  parameter int unsigned DD_DEPTH    = 80,
  parameter int unsigned LINE2_BASE  = 64,
  parameter int unsigned LONG_TICKS  = 410,
  parameter int unsigned SHORT_TICKS = 10,
  parameter logic [7:0]  BLANK       = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_rs,
  input  logic       req_rw,
  input  logic [7:0] req_data,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       ram_sel_cg,
  output logic [6:0] ram_addr,
  output logic       ram_we,
  output logic       ram_re,
  output logic [7:0] ram_wdata,
  input  logic [7:0] ram_rdata,
  output logic       busy,
  output logic [6:0] addr_ctr,
  output logic       target_cg,
  output logic       incr_mode,
  output logic       scroll_mode,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic [6:0] shift_ofs,
  output logic       bus_8bit,
  output logic       two_line,
  output logic       tall_font
);

  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned CG_W     = 6;
  localparam int unsigned LINE_LEN = DD_DEPTH / 2;
  localparam logic [ADDR_W-1:0] WALK_LAST = ADDR_W'(DD_DEPTH - 1);
  localparam logic [ADDR_W-1:0] LINE_GAP  = ADDR_W'(LINE2_BASE - LINE_LEN);

  // ---------------------------------------------------------------- state
  logic [ADDR_W-1:0] ac_q, ofs_q, walk_idx_q;
  logic              cg_q, incr_q, scroll_q, disp_q, cur_q, blink_q;
  logic              dl_q, two_q, tall_q, walking_q;
  logic              rd_pend_q, stat_pend_q;
  logic [7:0]        stat_q;

  // ---------------------------------------------------------------- handshake
  logic is_stat, timer_busy, acc, acc_cmd, acc_wr, acc_rd, acc_stat, acc_data;
  op_e  op;

  assign is_stat   = !req_rs && req_rw;
  assign busy      = timer_busy || walking_q;
  assign req_ready = is_stat || !busy;
  assign acc       = req_valid && req_ready;
  assign acc_cmd   = acc && !req_rs && !req_rw;
  assign acc_wr    = acc && req_rs && !req_rw;
  assign acc_rd    = acc && req_rs && req_rw;
  assign acc_stat  = acc && is_stat;
  assign acc_data  = acc_wr || acc_rd;

  lcd_cmd_decode #(.BYTE_W(8)) u_dec (
    .cmd (req_data),
    .op  (op)
  );

  // ---------------------------------------------------------------- steppers
  logic [ADDR_W-1:0] ac_nxt, ofs_nxt;
  logic              step_up, ofs_fwd;

  assign step_up = acc_cmd ? req_data[2] : incr_q;
  assign ofs_fwd = acc_cmd ? !req_data[2] : incr_q;

  lcd_addr_step #(
    .ADDR_W(ADDR_W), .CG_W(CG_W), .DD_DEPTH(DD_DEPTH), .LINE2_BASE(LINE2_BASE)
  ) u_ac_step (
    .addr     (ac_q),
    .up       (step_up),
    .to_cg    (cg_q),
    .two_line (two_q),
    .nxt      (ac_nxt)
  );

  lcd_ofs_step #(.ADDR_W(ADDR_W), .DD_DEPTH(DD_DEPTH)) u_ofs_step (
    .ofs      (ofs_q),
    .fwd      (ofs_fwd),
    .two_line (two_q),
    .nxt      (ofs_nxt)
  );

  // ---------------------------------------------------------------- busy timer
  logic timer_start, timer_long;

  assign timer_start = (acc_cmd && op != OP_NOP) || acc_data;
  assign timer_long  = acc_cmd && (op == OP_CLEAR || op == OP_HOME);

  lcd_busy_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (timer_start),
    .long_sel (timer_long),
    .tick     (osc_tick),
    .busy     (timer_busy)
  );

  // ---------------------------------------------------------------- clear walk
  logic [ADDR_W-1:0] walk_addr;

  assign walk_addr = (two_q && walk_idx_q >= ADDR_W'(LINE_LEN)) ?
                     walk_idx_q + LINE_GAP : walk_idx_q;

  // ---------------------------------------------------------------- memory port
  assign ram_we     = walking_q || acc_wr;
  assign ram_re     = acc_rd;
  assign ram_sel_cg = walking_q ? 1'b0 : cg_q;
  assign ram_addr   = walking_q ? walk_addr : ac_q;
  assign ram_wdata  = walking_q ? BLANK : req_data;

  // ---------------------------------------------------------------- state update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_q       <= '0;
      ofs_q      <= '0;
      walk_idx_q <= '0;
      cg_q       <= 1'b0;
      incr_q     <= 1'b1;
      scroll_q   <= 1'b0;
      disp_q     <= 1'b0;
      cur_q      <= 1'b0;
      blink_q    <= 1'b0;
      dl_q       <= 1'b1;
      two_q      <= 1'b0;
      tall_q     <= 1'b0;
      walking_q  <= 1'b0;
    end else begin
      if (walking_q) begin
        walk_idx_q <= walk_idx_q + 1'b1;
        if (walk_idx_q == WALK_LAST) walking_q <= 1'b0;
      end
      if (acc_cmd) begin
        unique case (op)
          OP_CLEAR: begin
            ac_q       <= '0;
            ofs_q      <= '0;
            cg_q       <= 1'b0;
            walking_q  <= 1'b1;
            walk_idx_q <= '0;
          end
          OP_HOME: begin
            ac_q  <= '0;
            ofs_q <= '0;
            cg_q  <= 1'b0;
          end
          OP_ENTRY: begin
            incr_q   <= req_data[1];
            scroll_q <= req_data[0];
          end
          OP_DISP: begin
            disp_q  <= req_data[2];
            cur_q   <= req_data[1];
            blink_q <= req_data[0];
          end
          OP_SHIFT: begin
            if (req_data[3]) ofs_q <= ofs_nxt;
            else             ac_q  <= ac_nxt;
          end
          OP_FUNC: begin
            dl_q   <= req_data[4];
            two_q  <= req_data[3];
            tall_q <= req_data[2];
            ofs_q  <= '0;
          end
          OP_CGADDR: begin
            ac_q <= ADDR_W'(req_data[CG_W-1:0]);
            cg_q <= 1'b1;
          end
          OP_DDADDR: begin
            ac_q <= req_data[ADDR_W-1:0];
            cg_q <= 1'b0;
          end
          default: ;
        endcase
      end else if (acc_data) begin
        ac_q <= ac_nxt;
        if (scroll_q && !cg_q) ofs_q <= ofs_nxt;
      end
    end
  end

  // ---------------------------------------------------------------- responses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q   <= 1'b0;
      stat_pend_q <= 1'b0;
      stat_q      <= '0;
    end else begin
      rd_pend_q   <= acc_rd;
      stat_pend_q <= acc_stat;
      if (acc_stat) stat_q <= {busy, ac_q};
    end
  end

  assign rsp_valid = rd_pend_q || stat_pend_q;
  assign rsp_data  = rd_pend_q ? ram_rdata : stat_q;

  // ---------------------------------------------------------------- outputs
  assign addr_ctr    = ac_q;
  assign target_cg   = cg_q;
  assign incr_mode   = incr_q;
  assign scroll_mode = scroll_q;
  assign disp_on     = disp_q;
  assign cursor_on   = cur_q;
  assign blink_on    = blink_q;
  assign shift_ofs   = ofs_q;
  assign bus_8bit    = dl_q;
  assign two_line    = two_q;
  assign tall_font   = tall_q;

  // ---------------------------------------------------------------- checks
  logic ac_dd_ok;

  assign ac_dd_ok = two_q ?
    ((ac_q < ADDR_W'(LINE_LEN)) ||
     (ac_q >= ADDR_W'(LINE2_BASE) && ac_q < ADDR_W'(LINE2_BASE + LINE_LEN))) :
    (ac_q < ADDR_W'(DD_DEPTH));

  AST_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(!req_rs && req_rw)) |-> !req_ready); // R12

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_rw && (req_rs || !req_rs)) |=> rsp_valid); // R13

  AST_OFS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ofs < (two_line ? ADDR_W'(LINE_LEN) : ADDR_W'(DD_DEPTH))); // R7

  AST_DD_STEP_STAYS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_rs && !target_cg && ac_dd_ok) |=> ac_dd_ok); // R10

  AST_NO_READ_DURING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    walking_q |-> (!ram_re && !ram_sel_cg)); // R3

endmodule

// File: tb/lcd_cmd_exec_test.sv
module lcd_cmd_exec_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_rs = 1'b0;
  logic       req_rw = 1'b0;
  logic [7:0] req_data = 8'h00;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       ram_sel_cg, ram_we, ram_re;
  logic [6:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata = 8'h00;
  logic       busy, target_cg, incr_mode, scroll_mode;
  logic       disp_on, cursor_on, blink_on, bus_8bit, two_line, tall_font;
  logic [6:0] addr_ctr, shift_ofs;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  logic [1:0] tick_div = 2'd0;
  always @(posedge clk) tick_div <= tick_div + 2'd1;
  assign osc_tick = (tick_div == 2'd3);

  // behavioural memories, one-cycle read latency
  logic [7:0] dd_mem [128];
  logic [7:0] cg_mem [64];
  initial begin
    for (int i = 0; i < 128; i++) dd_mem[i] = 8'hFF;
    for (int i = 0; i < 64; i++)  cg_mem[i] = 8'hFF;
  end
  always @(posedge clk) begin
    if (ram_we) begin
      if (ram_sel_cg) cg_mem[ram_addr[5:0]] <= ram_wdata;
      else            dd_mem[ram_addr]      <= ram_wdata;
    end
    if (ram_re) ram_rdata <= ram_sel_cg ? cg_mem[ram_addr[5:0]] : dd_mem[ram_addr];
  end

  lcd_cmd_exec uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_rs(req_rs), .req_rw(req_rw),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ram_sel_cg(ram_sel_cg), .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .busy(busy), .addr_ctr(addr_ctr),
    .target_cg(target_cg), .incr_mode(incr_mode), .scroll_mode(scroll_mode),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
    .shift_ofs(shift_ofs), .bus_8bit(bus_8bit), .two_line(two_line),
    .tall_font(tall_font)
  );

  // {rs, rw, byte, expected counter, expected offset}
  localparam int NV = 34;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0,1'b0,8'h30,7'd0,7'd0},     // R8 one line
    {1'b0,1'b0,8'hCF,7'd79,7'd0},    // R9 display address 79
    {1'b1,1'b0,8'h41,7'd0,7'd0},     // R10 79 -> 0
    {1'b0,1'b0,8'h04,7'd0,7'd0},     // R5 decrement
    {1'b1,1'b0,8'h42,7'd79,7'd0},    // R10 0 -> 79
    {1'b0,1'b0,8'h07,7'd79,7'd0},    // R5 increment + scroll
    {1'b1,1'b0,8'h43,7'd0,7'd1},     // R5 scroll +1
    {1'b0,1'b0,8'h18,7'd0,7'd2},     // R7 scroll left
    {1'b0,1'b0,8'h1F,7'd0,7'd1},     // R2 R7 right, low bits ignored
    {1'b0,1'b0,8'h1C,7'd0,7'd0},     // R7
    {1'b0,1'b0,8'h1C,7'd0,7'd79},    // R7 offset wrap
    {1'b0,1'b0,8'h14,7'd1,7'd79},    // R7 cursor right
    {1'b0,1'b0,8'h10,7'd0,7'd79},    // R7 cursor left
    {1'b0,1'b0,8'h10,7'd79,7'd79},   // R10 cursor wrap
    {1'b0,1'b0,8'h05,7'd79,7'd79},   // R5 decrement + scroll
    {1'b1,1'b0,8'h44,7'd78,7'd78},   // R5 scroll -1
    {1'b0,1'b0,8'h03,7'd0,7'd0},     // R4 R2 home, bit 0 ignored
    {1'b0,1'b0,8'h38,7'd0,7'd0},     // R8 two lines
    {1'b0,1'b0,8'hA7,7'd39,7'd0},    // R9
    {1'b0,1'b0,8'h06,7'd39,7'd0},    // R5
    {1'b1,1'b0,8'h45,7'd64,7'd0},    // R10 27h -> 40h
    {1'b0,1'b0,8'hE7,7'd103,7'd0},   // R9
    {1'b1,1'b0,8'h46,7'd0,7'd0},     // R10 67h -> 00h
    {1'b0,1'b0,8'h04,7'd0,7'd0},     // R5
    {1'b1,1'b0,8'h47,7'd103,7'd0},   // R10 00h -> 67h
    {1'b0,1'b0,8'hC0,7'd64,7'd0},    // R9
    {1'b1,1'b0,8'h48,7'd39,7'd0},    // R10 40h -> 27h
    {1'b0,1'b0,8'h1C,7'd39,7'd39},   // R7 two-line offset wrap
    {1'b0,1'b0,8'h45,7'd5,7'd39},    // R9 pattern address
    {1'b0,1'b0,8'h07,7'd5,7'd39},    // R5
    {1'b1,1'b0,8'h11,7'd6,7'd39},    // R5 no scroll on pattern memory
    {1'b0,1'b0,8'h7F,7'd63,7'd39},   // R9
    {1'b1,1'b0,8'h12,7'd0,7'd39},    // R10 6-bit wrap
    {1'b0,1'b0,8'h01,7'd0,7'd0}      // R3 clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic rs, input logic rw, input logic [7:0] d);
    @(negedge clk);
    req_rs = rs; req_rw = rw; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 counter", addr_ctr, 0);
    check("R1 offset", shift_ofs, 0);
    check("R1 flags", {busy, target_cg, incr_mode, scroll_mode, disp_on, cursor_on,
                       blink_on, bus_8bit, two_line, tall_font, req_ready},
          11'b00100001001);

    // R2 no-op byte leaves the block idle
    push(1'b0, 1'b0, 8'h00);
    check("R2 nop busy", busy, 0);

    for (int i = 0; i < NV; i++) begin
      push(VEC[i][23], VEC[i][22], VEC[i][21:14]);
      wait_idle();
      check($sformatf("R5/R7/R9/R10 row %0d counter", i), addr_ctr, VEC[i][13:7]);
      check($sformatf("R5/R7/R9/R10 row %0d offset", i), shift_ofs, VEC[i][6:0]);
    end

    // R3 clear in two-line mode: valid ranges blanked, gap untouched
    check("R3 blank 00h", dd_mem[0], 8'h20);
    check("R3 blank 4Fh", dd_mem[79], 8'h20);
    check("R3 gap 30h untouched", dd_mem[48], 8'hFF);
    check("R3 target display", target_cg, 0);

    // R13 data read back through the block
    push(1'b0, 1'b0, 8'h06); wait_idle();
    push(1'b0, 1'b0, 8'h85); wait_idle();
    push(1'b1, 1'b0, 8'h5A); wait_idle();
    push(1'b0, 1'b0, 8'h85); wait_idle();
    push(1'b1, 1'b1, 8'h00);
    check("R13 read valid", rsp_valid, 1);
    check("R13 read data", rsp_data, 8'h5A);
    wait_idle();
    check("R5 read steps counter", addr_ctr, 6);
    push(1'b0, 1'b0, 8'hE7); wait_idle();
    push(1'b1, 1'b1, 8'h00);
    check("R3 67h blanked", rsp_data, 8'h20);
    wait_idle();

    // R11 short busy window
    push(1'b0, 1'b0, 8'h0C);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    check("R11 short busy", (cyc >= 36 && cyc <= 41), 1);

    // R12 back-pressure and status read during long busy (home)
    push(1'b0, 1'b0, 8'h02);
    check("R12 busy after home", busy, 1);
    req_rs = 1'b1; req_rw = 1'b0; req_data = 8'h77; req_valid = 1'b1;
    #1 check("R12 write stalled", req_ready, 0);
    req_rs = 1'b0; req_rw = 1'b1;
    #1 check("R12 status ready", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R13 status valid", rsp_valid, 1);
    check("R13 status data", rsp_data, 8'h80);
    cyc = 2;
    while (busy) begin cyc++; @(negedge clk); end
    check("R11 long busy", (cyc >= 1636 && cyc <= 1641), 1);
    check("R4 home keeps memory", dd_mem[5], 8'h5A);
    check("R4 home counter", addr_ctr, 0);

    // R6 display control
    push(1'b0, 1'b0, 8'h0F); wait_idle();
    check("R6 all on", {disp_on, cursor_on, blink_on}, 3'b111);
    push(1'b0, 1'b0, 8'h0A); wait_idle();
    check("R6 cursor only", {disp_on, cursor_on, blink_on}, 3'b010);

    // R8 function fields
    push(1'b0, 1'b0, 8'h27); wait_idle();
    check("R8 fields", {bus_8bit, two_line, tall_font}, 3'b001);
    push(1'b0, 1'b0, 8'h3C); wait_idle();
    check("R8 fields 2", {bus_8bit, two_line, tall_font}, 3'b111);

    summary();
  end

endmodule